// File: doc/BRIEF.md
# XGMII start-of-frame lane aligner

This block sits on the single-data-rate receive side of a 10 Gb/s Ethernet link. Each clock it takes a 72-bit XGMII-style word: eight data bytes and one control flag per byte. A frame may open with its start character in any byte lane. The block re-packs the byte stream so that every frame's start character leaves in lane 0 of the output word. Each byte keeps its own control flag. Anything that inspects whole frames downstream, such as a trigger matcher, then sees every frame in the same layout.

A small state machine tracks three conditions: idle, a frame passing straight through when it started in lane 0, and a frame being shifted by a held offset. While a frame is shifted, the upper bytes of one word wait in a one-word holding register and join the lower bytes of the next word. When the terminate character arrives, the lanes after it are filled with idle characters. If the tail bytes still sit in the holding register, they leave on the following cycle. A valid flag and a start-of-frame marker go with each aligned word.

Top module: `xgmii_sof_aligner`

## Requirements
- R1: While rst_ni is low and after its release, the output carries idle words: al_valid_o=0, al_sof_o=0, every control flag 1 and every data byte 0x07. No byte from before reset appears in the first frame after it.
- R2: A start character is a byte with its control flag set and the value 0xFB. Whichever lane it arrives in, the frame leaves as consecutive aligned words with the start character in lane 0 (bits 7:0, control bit 0) and the frame bytes in input order. Each byte keeps its control flag.
- R3: A frame whose start character is in lane 0 passes straight through. Each of its words appears on the outputs after the clock edge that samples it.
- R4: A frame whose start character is in lane k>0, and which does not end in that word, gives an idle output after the edge that samples the start. Its first aligned word follows the next edge, formed from lanes k..7 of the held word and lanes 0..k-1 of the new one.
- R5: A terminate character is a byte with its control flag set and the value 0xFD. In the aligned word that carries it, every higher lane is replaced by an idle byte (control 1, data 0x07).
- R6: If a shifted frame's terminate lies in a lane at or above its offset, the last aligned word leaves one cycle after the word that closes the previous group. It holds the tail bytes from the holding register, padded with idle bytes.
- R7: al_valid_o is high exactly on aligned words that carry frame bytes. When it is low, the output is an idle word and al_sof_o is low.
- R8: al_sof_o is high only on the first aligned word of each frame, and that word holds the start character in lane 0.
- R9: No frame byte is dropped or duplicated. The number of bytes from start through terminate on valid output words equals the number sent.
- R10: A frame whose start and terminate fall in the same input word leaves as one aligned word after the edge that samples that word.
- R11: A new frame may start in the input word sampled on the cycle a previous shifted frame flushes its tail. It is then aligned by its own offset, with no byte lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | LANES*8 | Receive data bytes, lane 0 in bits 7:0 |
| rx_ctrl_i | input | LANES | Receive control flags, one per lane |
| al_data_o | output | LANES*8 | Aligned data bytes |
| al_ctrl_o | output | LANES | Aligned control flags |
| al_valid_o | output | 1 | Aligned word carries frame bytes |
| al_sof_o | output | 1 | First aligned word of a frame |

## Verification
The assertions assume at least eight idle bytes between a terminate character and the next start character. Under that assumption no word holds more than one start or terminate, and a flush cycle never meets a new frame starting in lane 0. The stimulus builds each frame by inserting eight idle bytes and then further idles until the start lands in the chosen lane, so no input breaks that spacing. Several scenarios use exactly the minimum gap, so that a new start meets a tail flush.

// File: rtl/xga_pkg.sv
`timescale 1ns/1ps
package xga_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CH_START = 8'hFB;
  localparam logic [BYTE_W-1:0] CH_TERM  = 8'hFD;
  localparam logic [BYTE_W-1:0] CH_IDLE  = 8'h07;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIRECT,
    ST_SHIFT
  } align_st_e;
endpackage

// File: rtl/xga_char_scan.sv
`timescale 1ns/1ps
module xga_char_scan
  import xga_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter logic [BYTE_W-1:0] CHAR = CH_START
) (
  input  logic [LANES*BYTE_W-1:0]   data_i,
  input  logic [LANES-1:0]          ctrl_i,
  output logic                      any_o,
  output logic [$clog2(LANES)-1:0]  lane_o
);
  localparam int unsigned IDX_W = $clog2(LANES);

  logic [LANES-1:0] hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hit[l] = ctrl_i[l] && (data_i[l*BYTE_W +: BYTE_W] == CHAR);
  end

  assign any_o = |hit;

  // lowest matching lane wins
  always_comb begin
    lane_o = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (hit[l]) lane_o = IDX_W'(l);
    end
  end
endmodule

// File: rtl/xga_window.sv
`timescale 1ns/1ps
module xga_window
  import xga_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic [LANES*BYTE_W-1:0]       lo_data_i,
  input  logic [LANES-1:0]              lo_ctrl_i,
  input  logic [LANES*BYTE_W-1:0]       hi_data_i,
  input  logic [LANES-1:0]              hi_ctrl_i,
  input  logic [$clog2(2*LANES)-1:0]    shift_i,
  output logic [LANES*BYTE_W-1:0]       data_o,
  output logic [LANES-1:0]              ctrl_o
);
  localparam int unsigned SPAN = 2 * LANES;

  logic [SPAN*BYTE_W-1:0] wide_data;
  logic [SPAN-1:0]        wide_ctrl;

  assign wide_data = {hi_data_i, lo_data_i};
  assign wide_ctrl = {hi_ctrl_i, lo_ctrl_i};

  // byte j of the output is byte (shift+j) of the two-word span; beyond it, idle
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      int src;
      src = int'(shift_i) + j;
      if (src < SPAN) begin
        data_o[j*BYTE_W +: BYTE_W] = wide_data[src*BYTE_W +: BYTE_W];
        ctrl_o[j]                  = wide_ctrl[src];
      end else begin
        data_o[j*BYTE_W +: BYTE_W] = CH_IDLE;
        ctrl_o[j]                  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xga_term_pad.sv
`timescale 1ns/1ps
module xga_term_pad
  import xga_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic [LANES*BYTE_W-1:0] data_i,
  input  logic [LANES-1:0]        ctrl_i,
  output logic [LANES*BYTE_W-1:0] data_o,
  output logic [LANES-1:0]        ctrl_o,
  output logic                    term_o
);
  localparam int unsigned IDX_W = $clog2(LANES);

  logic             term_any;
  logic [IDX_W-1:0] term_lane;

  xga_char_scan #(
    .LANES (LANES),
    .CHAR  (CH_TERM)
  ) u_term_scan (
    .data_i (data_i),
    .ctrl_i (ctrl_i),
    .any_o  (term_any),
    .lane_o (term_lane)
  );

  assign term_o = term_any;

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      if (term_any && (IDX_W'(j) > term_lane)) begin
        data_o[j*BYTE_W +: BYTE_W] = CH_IDLE;
        ctrl_o[j]                  = 1'b1;
      end else begin
        data_o[j*BYTE_W +: BYTE_W] = data_i[j*BYTE_W +: BYTE_W];
        ctrl_o[j]                  = ctrl_i[j];
      end
    end
  end
endmodule

// File: rtl/xgmii_sof_aligner.sv
`timescale 1ns/1ps
module xgmii_sof_aligner
  import xga_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES*BYTE_W-1:0] rx_data_i,
  input  logic [LANES-1:0]        rx_ctrl_i,
  output logic [LANES*BYTE_W-1:0] al_data_o,
  output logic [LANES-1:0]        al_ctrl_o,
  output logic                    al_valid_o,
  output logic                    al_sof_o
);
  localparam int unsigned DW    = LANES * BYTE_W;
  localparam int unsigned IDX_W = $clog2(LANES);
  localparam int unsigned SEL_W = $clog2(2 * LANES);
  localparam logic [DW-1:0] IDLE_WORD = {LANES{CH_IDLE}};

  logic [DW-1:0]    hold_data_q;
  logic [LANES-1:0] hold_ctrl_q;
  align_st_e        st_q, st_d;
  logic [IDX_W-1:0] off_q, off_d;
  logic             first_q, first_d;

  logic             start_any;
  logic [IDX_W-1:0] start_lane;
  logic [SEL_W-1:0] sel;
  logic [DW-1:0]    win_data, pad_data;
  logic [LANES-1:0] win_ctrl, pad_ctrl;
  logic             win_term;
  logic             emit, emit_sof;

  xga_char_scan #(
    .LANES (LANES),
    .CHAR  (CH_START)
  ) u_start_scan (
    .data_i (rx_data_i),
    .ctrl_i (rx_ctrl_i),
    .any_o  (start_any),
    .lane_o (start_lane)
  );

  xga_window #(
    .LANES (LANES)
  ) u_window (
    .lo_data_i (hold_data_q),
    .lo_ctrl_i (hold_ctrl_q),
    .hi_data_i (rx_data_i),
    .hi_ctrl_i (rx_ctrl_i),
    .shift_i   (sel),
    .data_o    (win_data),
    .ctrl_o    (win_ctrl)
  );

  xga_term_pad #(
    .LANES (LANES)
  ) u_pad (
    .data_i (win_data),
    .ctrl_i (win_ctrl),
    .data_o (pad_data),
    .ctrl_o (pad_ctrl),
    .term_o (win_term)
  );

  // window origin: LANES+k points into the live word, k into the held word
  always_comb begin
    unique case (st_q)
      ST_IDLE:  sel = start_any ? SEL_W'(LANES) + SEL_W'(start_lane) : SEL_W'(LANES);
      ST_SHIFT: sel = SEL_W'(off_q);
      default:  sel = SEL_W'(LANES);
    endcase
  end

  always_comb begin
    st_d     = st_q;
    off_d    = off_q;
    first_d  = first_q;
    emit     = 1'b0;
    emit_sof = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_any) begin
          if (start_lane == '0 || win_term) begin
            emit     = 1'b1;
            emit_sof = 1'b1;
            st_d     = win_term ? ST_IDLE : ST_DIRECT;
          end else begin
            off_d   = start_lane;
            first_d = 1'b1;
            st_d    = ST_SHIFT;
          end
        end
      end
      ST_DIRECT: begin
        emit = 1'b1;
        if (win_term) st_d = ST_IDLE;
      end
      ST_SHIFT: begin
        emit     = 1'b1;
        emit_sof = first_q;
        first_d  = 1'b0;
        if (win_term) begin
          // tail leaves now; a start in the live word opens the next frame
          if (start_any) begin
            off_d   = start_lane;
            first_d = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_data_q <= IDLE_WORD;
      hold_ctrl_q <= '1;
      st_q        <= ST_IDLE;
      off_q       <= '0;
      first_q     <= 1'b0;
      al_data_o   <= IDLE_WORD;
      al_ctrl_o   <= '1;
      al_valid_o  <= 1'b0;
      al_sof_o    <= 1'b0;
    end else begin
      hold_data_q <= rx_data_i;
      hold_ctrl_q <= rx_ctrl_i;
      st_q        <= st_d;
      off_q       <= off_d;
      first_q     <= first_d;
      al_valid_o  <= emit;
      al_sof_o    <= emit_sof;
      al_data_o   <= emit ? pad_data : IDLE_WORD;
      al_ctrl_o   <= emit ? pad_ctrl : '1;
    end
  end

  assert_lane0_direct_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_any && start_lane == '0)
      |=> (al_valid_o && al_sof_o && al_data_o[BYTE_W-1:0] == CH_START));

  assert_shift_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_any && start_lane != '0 && !win_term)
      |=> !al_valid_o ##1 (al_valid_o && al_sof_o));

  assert_single_word_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_any && start_lane != '0 && win_term)
      |=> (al_valid_o && al_sof_o));

  assert_idle_when_invalid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !al_valid_o |-> (al_ctrl_o == '1 && al_data_o == IDLE_WORD && !al_sof_o));

  assert_sof_lane0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al_sof_o |-> (al_valid_o && al_ctrl_o[0] && al_data_o[BYTE_W-1:0] == CH_START));

  for (genvar j = 0; j < LANES - 1; j++) begin : g_pad_chk
    assert_pad_after_term_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (al_valid_o && al_ctrl_o[j] && al_data_o[j*BYTE_W +: BYTE_W] == CH_TERM)
        |-> (al_ctrl_o[LANES-1:j+1] == '1 &&
             al_data_o[DW-1:(j+1)*BYTE_W] == {(LANES-1-j){CH_IDLE}}));
  end
endmodule

// File: tb/xgmii_sof_aligner_tb_top.sv
`timescale 1ns/1ps
module xgmii_sof_aligner_tb_top;
  localparam int LANES = 8;
  localparam logic [7:0] S_CH = 8'hFB;
  localparam logic [7:0] T_CH = 8'hFD;
  localparam logic [7:0] I_CH = 8'h07;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [LANES*8-1:0]   rx_data;
  logic [LANES-1:0]     rx_ctrl;
  logic [LANES*8-1:0]   al_data;
  logic [LANES-1:0]     al_ctrl;
  logic                 al_valid;
  logic                 al_sof;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [8:0] strm[$];
  logic [8:0] part[$];
  logic [72:0] outq[$];
  bit   in_frame = 0;
  bit   first_grp = 0;
  int   bytes_in = 0;
  int   bytes_out = 0;
  bit   exp_v, exp_s;
  logic [71:0] exp_w;

  always #2.5 clk = ~clk;

  xgmii_sof_aligner #(.LANES(LANES)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rx_data_i  (rx_data),
    .rx_ctrl_i  (rx_ctrl),
    .al_data_o  (al_data),
    .al_ctrl_o  (al_ctrl),
    .al_valid_o (al_valid),
    .al_sof_o   (al_sof)
  );

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic void finalize();
    logic [71:0] w;
    w = {8'hFF, {8{I_CH}}};
    for (int i = 0; i < part.size(); i++) begin
      w[64+i]      = part[i][8];
      w[i*8 +: 8]  = part[i][7:0];
    end
    outq.push_back({first_grp, w});
    first_grp = 0;
    part.delete();
  endfunction

  function automatic void model_step(input logic [63:0] d, input logic [7:0] c);
    for (int l = 0; l < LANES; l++) begin
      logic [8:0] e;
      e = {c[l], d[l*8 +: 8]};
      if (!in_frame && c[l] && d[l*8 +: 8] == S_CH) begin
        in_frame  = 1;
        first_grp = 1;
      end
      if (in_frame) begin
        part.push_back(e);
        bytes_in++;
        if (c[l] && d[l*8 +: 8] == T_CH) begin
          in_frame = 0;
          finalize();
        end else if (part.size() == LANES) begin
          finalize();
        end
      end
    end
    if (outq.size() > 0) begin
      logic [72:0] g;
      g = outq.pop_front();
      exp_v = 1;
      exp_s = g[72];
      exp_w = g[71:0];
    end else begin
      exp_v = 0;
      exp_s = 0;
      exp_w = {8'hFF, {8{I_CH}}};
    end
  endfunction

  task automatic compare(input string tag);
    if (exp_v) begin
      chk(al_valid === 1'b1, "R7", 80'(al_valid), 80'(1));
      chk(al_sof === exp_s, "R8", 80'(al_sof), 80'(exp_s));
      chk({al_ctrl, al_data} === exp_w, tag, 80'({al_ctrl, al_data}), 80'(exp_w));
    end else begin
      chk(al_valid === 1'b0 && al_sof === 1'b0, "R7", 80'({al_valid, al_sof}), 80'(0));
      chk({al_ctrl, al_data} === exp_w, "R7", 80'({al_ctrl, al_data}), 80'(exp_w));
    end
    if (al_valid === 1'b1) begin
      for (int l = 0; l < LANES; l++) begin
        bytes_out++;
        if (al_ctrl[l] && al_data[l*8 +: 8] == T_CH) break;
      end
    end
  endtask

  task automatic add_idle(input int n);
    for (int i = 0; i < n; i++) strm.push_back({1'b1, I_CH});
  endtask

  task automatic add_frame(input int lane, input int len);
    add_idle(8);
    while (strm.size() % LANES != lane) add_idle(1);
    strm.push_back({1'b1, S_CH});
    for (int i = 0; i < len; i++) strm.push_back({1'b0, 8'($urandom_range(0, 255))});
    strm.push_back({1'b1, T_CH});
  endtask

  task automatic feed(input string tag);
    add_idle(24);
    while (strm.size() % LANES != 0) add_idle(1);
    while (strm.size() >= LANES) begin
      logic [63:0] d;
      logic [7:0]  c;
      for (int l = 0; l < LANES; l++) begin
        logic [8:0] e;
        e = strm.pop_front();
        c[l] = e[8];
        d[l*8 +: 8] = e[7:0];
      end
      @(negedge clk);
      rx_data = d;
      rx_ctrl = c;
      @(posedge clk);
      model_step(d, c);
      #1;
      compare(tag);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    rx_data = {8{I_CH}};
    rx_ctrl = '1;
    repeat (3) @(negedge clk);
    // R1: idle outputs during reset
    chk(al_valid === 1'b0 && al_sof === 1'b0, "R1", 80'({al_valid, al_sof}), 80'(0));
    chk({al_ctrl, al_data} === {8'hFF, {8{I_CH}}}, "R1", 80'({al_ctrl, al_data}), 80'({8'hFF, {8{I_CH}}}));
    rst_n = 1'b1;
    @(negedge clk);
    chk({al_valid, al_ctrl, al_data} === {1'b0, 8'hFF, {8{I_CH}}}, "R1",
        80'({al_valid, al_ctrl, al_data}), 80'({1'b0, 8'hFF, {8{I_CH}}}));
    // R1: first frame after reset aligned from lane 4
    add_frame(4, 64);
    feed("R1");

    // R3: lane-0 pass-through
    add_frame(0, 64);
    add_frame(0, 70);
    add_frame(0, 100);
    feed("R3");

    // R4: lane-4 offset, every terminate lane
    for (int len = 64; len < 72; len++) add_frame(4, len);
    feed("R4");

    // R5: padding after terminate in every lane, direct path
    for (int len = 60; len < 68; len++) add_frame(0, len);
    feed("R5");

    // R6: terminate at or above the offset forces a flush cycle
    add_frame(4, 63);
    add_frame(4, 64);
    add_frame(4, 65);
    add_frame(2, 66);
    add_frame(7, 70);
    feed("R6");

    // R2: every start lane
    for (int ln = 1; ln < LANES; ln++) add_frame(ln, 50 + ln);
    for (int ln = 0; ln < LANES; ln++) add_frame(ln, 61 + ln);
    feed("R2");

    // R10: start and terminate in one word
    add_frame(1, 2);
    add_frame(3, 1);
    add_frame(0, 5);
    add_frame(5, 0);
    feed("R10");

    // R11: minimum gap, new start lands in the flush word
    add_frame(4, 63);
    add_frame(5, 70);
    add_frame(6, 65);
    add_frame(7, 64);
    add_frame(3, 68);
    feed("R11");

    // R9: byte conservation over all frames
    chk(bytes_out == bytes_in, "R9", 80'(bytes_out), 80'(bytes_in));
    chk(bytes_in > 0, "R9", 80'(bytes_in), 80'(1));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule